// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Controller

This block holds the receive and transmit byte queues of a UART and the control word that governs them. One write port loads a control word. That word holds a one-shot flush request for each queue, a receiver disable bit, and two 4-bit threshold codes. One code sets the fill level at which the receive side reports data available. The other sets the level at which the block tells the remote sender to pause. Both codes turn into byte counts through the same table. For the upper codes the count depends on a speed-mode input.

A flush request does not clear in the same cycle. It holds its queue empty for a fixed number of engine clock cycles. While it is active the queue drops push and pop requests, and the control readback shows the flush bit as 1. The serial shifters sit outside this block. They push received bytes in and pop transmit bytes out.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: Threshold codes 0, 1, 2 and 3 give 1, 4, 8 and 14 bytes, whatever the speed mode.
- R2: Codes 4, 5 and 6 give 30, 46 and 62 bytes when `hs_mode` is 1. Codes 7 to 15 give 62 bytes when `hs_mode` is 1. Codes 4 to 15 all give 14 bytes when `hs_mode` is 0.
- R3: `rda_flag` is 1 while the receive count is at or above the decoded receive level. So it rises when the count reaches the level, and it falls once the count drops below. `rda_irq` equals `rda_flag` gated by `rda_ien`.
- R4: Writing 1 to control bit 0 empties the receive queue and clears `rx_overrun`. It leaves the transmit queue untouched. Writing 0 to bit 0 changes nothing.
- R5: Writing 1 to control bit 1 empties the transmit queue and leaves the receive queue untouched.
- R6: After a flush write, the flush bit reads back 1 for exactly 3 cycles and then reads 0. During that time the flushed queue accepts no pushes.
- R7: While control bit 2 (receiver disable) is 1, receive pushes are dropped. When it is 0, they are accepted.
- R8: `rts_ready` is 0 while the receive count is at or above the level decoded from the flow code, and 1 while the count is below it.
- R9: Each queue holds 64 bytes. A receive push into a full queue is dropped and sets the sticky `rx_overrun`.
- R10: Each queue returns bytes in the order they were pushed. The read data always shows the oldest byte.
- R11: The control word is laid out as follows: bit 0 is the receive flush, bit 1 is the transmit flush, bit 2 is the receiver disable, bits [6:3] are the receive threshold code and bits [10:7] are the flow threshold code. Readback returns the stored fields, with bits 0 and 1 showing whether each flush is still active.
- R12: After a synchronous reset both counts are 0, the control word reads 0, `rts_ready` is 1, and `rda_flag`, `rda_irq` and `rx_overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_mode | input | 1 | 1 selects the high-speed threshold table |
| rda_ien | input | 1 | Enable for the data-available interrupt |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 11 | Control word write data |
| cfg_rdata | output | 11 | Control word readback |
| rx_push | input | 1 | Push a received byte |
| rx_din | input | 8 | Received byte |
| rx_pop | input | 1 | Pop the oldest received byte |
| rx_dout | output | 8 | Oldest received byte |
| rx_count | output | 7 | Receive queue fill level |
| rx_overrun | output | 1 | Sticky receive overrun |
| rda_flag | output | 1 | Receive data available |
| rda_irq | output | 1 | Masked data-available interrupt |
| rts_ready | output | 1 | Flow control, 1 = ready to receive |
| tx_push | input | 1 | Push a byte to transmit |
| tx_din | input | 8 | Byte to transmit |
| tx_pop | input | 1 | Pop the oldest transmit byte |
| tx_dout | output | 8 | Oldest transmit byte |
| tx_count | output | 7 | Transmit queue fill level |

## Verification
The threshold decoder is tried with all sixteen codes in both speed modes. For each one the receive queue is filled one byte at a time, which shows the exact count where `rda_flag` and `rts_ready` switch. This separates the low codes, which do not depend on the mode, from the upper codes, where the two modes give different levels. Directed sequences then fill the queue to overflow, cross the level in both directions with the enable on and off, and flush one side while the other holds data. They also issue a push in the middle of a flush, which tells a correctly held flush apart from one that releases early.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int CFG_W = 11;
    localparam int LVL_W = 7;

    typedef struct packed {
        logic [3:0] flow_code;
        logic [3:0] rx_code;
        logic       rx_off;
        logic       tx_flush;
        logic       rx_flush;
    } ctrl_word_t;

    function automatic logic [LVL_W-1:0] code_to_level(input logic [3:0] code, input logic fast);
        logic [LVL_W-1:0] lvl;
        case (code)
            4'd0:    lvl = 7'd1;
            4'd1:    lvl = 7'd4;
            4'd2:    lvl = 7'd8;
            4'd3:    lvl = 7'd14;
            4'd4:    lvl = fast ? 7'd30 : 7'd14;
            4'd5:    lvl = fast ? 7'd46 : 7'd14;
            default: lvl = fast ? 7'd62 : 7'd14;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/flush_hold.sv
module flush_hold #(
    parameter int HOLD = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int HW = $clog2(HOLD + 1);

    logic [HW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            left <= '0;
        end else if (start) begin
            busy <= 1'b1;
            left <= HW'(HOLD - 1);
        end else if (busy) begin
            if (left == '0) busy <= 1'b0;
            else            left <= left - 1'b1;
        end
    end

    // R6
    hold_min_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy);

endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !clr && !full;
    assign do_pop  = pop && !clr && (count != '0);
    assign dout    = mem[rp];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R4
    clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> count == '0);

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !clr) |=> count == CW'(DEPTH));

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int HOLD  = 3,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hs_mode,
    input  logic             rda_ien,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             rx_push,
    input  logic [DW-1:0]    rx_din,
    input  logic             rx_pop,
    output logic [DW-1:0]    rx_dout,
    output logic [CW-1:0]    rx_count,
    output logic             rx_overrun,
    output logic             rda_flag,
    output logic             rda_irq,
    output logic             rts_ready,
    input  logic             tx_push,
    input  logic [DW-1:0]    tx_din,
    input  logic             tx_pop,
    output logic [DW-1:0]    tx_dout,
    output logic [CW-1:0]    tx_count
);
    ctrl_word_t wr, cfg_q, rd;
    logic       rx_busy, tx_busy, rx_full, tx_full;
    logic       rx_accept;
    logic [CW-1:0] rx_lvl, flow_lvl;

    assign wr = ctrl_word_t'(cfg_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q.flow_code <= wr.flow_code;
            cfg_q.rx_code   <= wr.rx_code;
            cfg_q.rx_off    <= wr.rx_off;
        end
    end

    always_comb begin
        rd          = cfg_q;
        rd.rx_flush = rx_busy;
        rd.tx_flush = tx_busy;
    end
    assign cfg_rdata = rd;

    flush_hold #(.HOLD(HOLD)) u_rx_hold (
        .clk(clk), .rst(rst), .start(cfg_we && wr.rx_flush), .busy(rx_busy));
    flush_hold #(.HOLD(HOLD)) u_tx_hold (
        .clk(clk), .rst(rst), .start(cfg_we && wr.tx_flush), .busy(tx_busy));

    assign rx_accept = rx_push && !cfg_q.rx_off;

    byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_q (
        .clk(clk), .rst(rst), .clr(rx_busy), .push(rx_accept), .din(rx_din),
        .pop(rx_pop), .dout(rx_dout), .count(rx_count), .full(rx_full));
    byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_q (
        .clk(clk), .rst(rst), .clr(tx_busy), .push(tx_push), .din(tx_din),
        .pop(tx_pop), .dout(tx_dout), .count(tx_count), .full(tx_full));

    always_ff @(posedge clk) begin
        if (rst || rx_busy)                 rx_overrun <= 1'b0;
        else if (rx_accept && rx_full)      rx_overrun <= 1'b1;
    end

    assign rx_lvl    = CW'(code_to_level(cfg_q.rx_code, hs_mode));
    assign flow_lvl  = CW'(code_to_level(cfg_q.flow_code, hs_mode));
    assign rda_flag  = (rx_count >= rx_lvl);
    assign rda_irq   = rda_flag && rda_ien;
    assign rts_ready = (rx_count < flow_lvl);

    // R7
    rx_off_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.rx_off && !cfg_we && !rx_pop && !rx_busy) |=> $stable(rx_count));

    // R9
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_push && !cfg_q.rx_off && rx_full && !rx_busy) |=> rx_overrun);

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_overrun && !rx_busy) |=> rx_overrun);

    // R4
    tx_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_busy && !tx_busy && !tx_push && !tx_pop && !(cfg_we && wr.tx_flush))
            |=> $stable(tx_count));

endmodule

// File: tb/uart_fifo_ctrl_test.sv
module uart_fifo_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hs_mode = 1'b0, rda_ien = 1'b0, cfg_we = 1'b0;
    logic [10:0] cfg_wdata = '0;
    logic [10:0] cfg_rdata;
    logic        rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0]  rx_din = '0, tx_din = '0, rx_dout, tx_dout;
    logic [6:0]  rx_count, tx_count;
    logic        rx_overrun, rda_flag, rda_irq, rts_ready;

    int checks = 0;
    int fails  = 0;

    localparam int LVL_FAST [16] = '{1, 4, 8, 14, 30, 46, 62, 62, 62, 62, 62, 62, 62, 62, 62, 62};
    localparam int LVL_SLOW [16] = '{1, 4, 8, 14, 14, 14, 14, 14, 14, 14, 14, 14, 14, 14, 14, 14};

    uart_fifo_ctrl uut (
        .clk(clk), .rst(rst), .hs_mode(hs_mode), .rda_ien(rda_ien),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop), .rx_dout(rx_dout),
        .rx_count(rx_count), .rx_overrun(rx_overrun), .rda_flag(rda_flag),
        .rda_irq(rda_irq), .rts_ready(rts_ready), .tx_push(tx_push), .tx_din(tx_din),
        .tx_pop(tx_pop), .tx_dout(tx_dout), .tx_count(tx_count));

    always #2 clk = ~clk;

    function automatic logic [10:0] word(input int flow, input int rxc, input bit off,
                                         input bit txf, input bit rxf);
        return {flow[3:0], rxc[3:0], off, txf, rxf};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic cfg_write(input logic [10:0] v);
        cfg_we = 1'b1; cfg_wdata = v; tick(); cfg_we = 1'b0;
    endtask

    task automatic rx_put(input logic [7:0] b);
        rx_push = 1'b1; rx_din = b; tick(); rx_push = 1'b0;
    endtask

    task automatic rx_take();
        rx_pop = 1'b1; tick(); rx_pop = 1'b0;
    endtask

    task automatic tx_put(input logic [7:0] b);
        tx_push = 1'b1; tx_din = b; tick(); tx_push = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        #0;
        // R12 reset state
        check(rx_count == 0 && tx_count == 0, "R12 counts", rx_count, 0);
        check(cfg_rdata == 0, "R12 control", cfg_rdata, 0);
        check(rts_ready == 1, "R12 rts", rts_ready, 1);
        check(!rda_flag && !rda_irq && !rx_overrun, "R12 flags",
              {rda_flag, rda_irq, rx_overrun}, 0);

        // R1 R2 R8 table walk over every code in both speed modes
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 16; c++) begin
                int exp_lvl, got;
                bit rts_early;
                hs_mode   = m[0];
                exp_lvl   = m ? LVL_FAST[c] : LVL_SLOW[c];
                got       = -1;
                rts_early = 0;
                cfg_write(word(c, c, 0, 0, 1));
                repeat (3) tick();
                for (int k = 1; k <= 64; k++) begin
                    rx_put(8'(k));
                    if (rda_flag) begin
                        got = k;
                        break;
                    end
                    if (!rts_ready) rts_early = 1;
                end
                check(got == exp_lvl, (c < 4) ? "R1 level" : "R2 level", got, exp_lvl);
                check(!rts_ready && !rts_early, "R8 rts switch", rts_ready, 0);
            end
        end

        hs_mode = 1'b0;
        // R10 order
        cfg_write(word(0, 0, 0, 0, 1));
        repeat (3) tick();
        rx_put(8'hA5); rx_put(8'h3C); rx_put(8'h7E);
        check(rx_dout == 8'hA5, "R10 first", rx_dout, 8'hA5);
        rx_take();
        check(rx_dout == 8'h3C, "R10 second", rx_dout, 8'h3C);
        rx_take();
        check(rx_dout == 8'h7E, "R10 third", rx_dout, 8'h7E);
        rx_take();
        check(rx_count == 0, "R10 empty", rx_count, 0);

        // R3 flag and interrupt with code 1 (4 bytes)
        cfg_write(word(15, 1, 0, 0, 0));
        rda_ien = 1'b1;
        rx_put(1); rx_put(2); rx_put(3);
        check(!rda_flag && !rda_irq, "R3 below", {rda_flag, rda_irq}, 0);
        rx_put(4);
        check(rda_flag && rda_irq, "R3 reached", {rda_flag, rda_irq}, 3);
        rda_ien = 1'b0; #1;
        check(rda_flag && !rda_irq, "R3 masked", {rda_flag, rda_irq}, 2);
        rda_ien = 1'b1;
        rx_take();
        check(!rda_flag && !rda_irq, "R3 dropped", {rda_flag, rda_irq}, 0);

        // R11 readback layout
        cfg_write(word(5, 2, 0, 0, 0));
        check(cfg_rdata == 11'b0101_0010_000, "R11 readback", cfg_rdata, 11'b0101_0010_000);

        // R9 fill to 64 and overflow
        cfg_write(word(15, 15, 0, 0, 1));
        repeat (3) tick();
        for (int k = 0; k < 64; k++) rx_put(8'(k + 16));
        check(rx_count == 64 && !rx_overrun, "R9 full", rx_count, 64);
        rx_put(8'hFF);
        check(rx_overrun == 1, "R9 overrun", rx_overrun, 1);
        check(rx_count == 64 && rx_dout == 8'd16, "R9 dropped", rx_dout, 16);

        // R4 R6 receive flush with transmit holding data
        tx_put(8'h11); tx_put(8'h22);
        cfg_write(word(15, 15, 0, 0, 1));
        check(cfg_rdata[0] == 1, "R6 busy 1", cfg_rdata[0], 1);
        rx_put(8'h55);
        check(cfg_rdata[0] == 1 && rx_count == 0, "R6 busy 2 no push", rx_count, 0);
        tick();
        check(cfg_rdata[0] == 1, "R6 busy 3", cfg_rdata[0], 1);
        tick();
        check(cfg_rdata[0] == 0, "R6 released", cfg_rdata[0], 0);
        check(rx_count == 0 && !rx_overrun, "R4 rx cleared", rx_count, 0);
        check(tx_count == 2 && tx_dout == 8'h11, "R4 tx kept", tx_count, 2);

        // R4 writing 0 has no effect
        rx_put(8'h66);
        cfg_write(word(15, 15, 0, 0, 0));
        tick();
        check(rx_count == 1 && cfg_rdata[0] == 0, "R4 zero write", rx_count, 1);

        // R5 transmit flush
        cfg_write(word(15, 15, 0, 1, 0));
        check(cfg_rdata[1] == 1, "R5 busy", cfg_rdata[1], 1);
        repeat (3) tick();
        check(tx_count == 0 && cfg_rdata[1] == 0, "R5 tx cleared", tx_count, 0);
        check(rx_count == 1, "R5 rx kept", rx_count, 1);

        // R7 receiver disable
        cfg_write(word(15, 15, 1, 0, 0));
        rx_put(8'h77);
        check(rx_count == 1 && cfg_rdata[2] == 1, "R7 disabled", rx_count, 1);
        cfg_write(word(15, 15, 0, 0, 0));
        rx_put(8'h78);
        check(rx_count == 2, "R7 enabled", rx_count, 2);

        finish_run();
    end
endmodule